// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block holds the software-visible registers of a simple bus-master DMA channel: a control/status word, a start address and a transfer count, each 32 bits wide. The memory transfer itself happens elsewhere. Its completion arrives here as a one-cycle `xfer_done` pulse that sets a sticky pending flag. The block drives one interrupt line, which is the pending flag gated by an enable bit.

The control/status word mixes fields that software may change with fields that it may not. A write keeps every bit under a fixed protected mask and takes the written value in the other bits. A version code in the top nibble is OR-ed into the word on every write. Writing the address register also sets a "loaded" flag, which is one of the protected bits. A write of all zeros to the control word sets the drain request instead of clearing everything. Setting the soft-reset bit clears the writable bits and the loaded flag one cycle later, and the soft-reset bit clears itself at the same time.

Top module: `dma_csr_regfile`

## Requirements
- R1: After the synchronous reset the control word reads 0xA0000000 (version nibble 0xA in bits 31:28, all other bits 0), the address and count registers read 0, and `irq` is low.
- R2: On a write to the control word (offset 0), every bit under the protected mask 0xFE000007 keeps its stored value, and every other bit takes the written value.
- R3: Bits 31:28 of the control word hold the version code `VERSION` (default 0xA) after every write, whatever was written.
- R4: A control write whose data is exactly zero leaves the word with drain bit 6 set and all other writable bits clear.
- R5: A one-cycle pulse on `xfer_done` sets pending bit 0 of the control word. Pending bit 0 is protected, so control writes do not clear it. `irq` is high exactly when pending bit 0 and enable bit 4 are both set. A write that sets bit 4 while pending is already set raises `irq` in the next cycle.
- R6: A write to offset 1 stores the address, and it sets loaded bit 26 of the control word in the same cycle.
- R7: When a control write sets soft-reset bit 7, the bit reads 1 for one cycle. On the following edge the writable bits and loaded bit 26 are cleared, while pending bit 0 and the version stay. The address and count registers are not affected.
- R8: Offset 2 stores the count value. Offset 3 always reads 0, and a write to it changes no register.
- R9: A control write that clears enable bit 4 lowers `irq` in the next cycle, even while pending stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word offset of the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| xfer_done | input | 1 | Transfer-complete pulse; sets pending |
| irq | output | 1 | Interrupt: pending AND enable |

## Verification
If the block held a wrong value in its protected field, it would show in the very next read of offset 0: a lost version nibble, a dropped pending flag or a loaded bit set when it should not be. The register value alone does not show a broken interrupt gate. It shows on `irq` one cycle after the write that changes the enable bit, so each enable change is followed by a check of both the word and the line. The soft-reset bit is observed in the one cycle when it is set, and again one cycle later, to tell a missing self-clear apart from a missing clear of the fields.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int REG_W = 32;
    localparam int OFS_W = 2;

    localparam logic [REG_W-1:0] PROT_MASK = 32'hFE00_0007;
    localparam int B_PEND   = 0;
    localparam int B_IEN    = 4;
    localparam int B_DRAIN  = 6;
    localparam int B_SRST   = 7;
    localparam int B_LOADED = 26;
    localparam int VER_LSB  = 28;

    localparam logic [REG_W-1:0] DRAIN_M  = REG_W'(1) << B_DRAIN;
    localparam logic [REG_W-1:0] LOADED_M = REG_W'(1) << B_LOADED;
    localparam logic [REG_W-1:0] PEND_M   = REG_W'(1) << B_PEND;

    typedef enum logic [OFS_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             en;
        reg_sel_e         sel;
        logic [REG_W-1:0] data;
    } wr_req_t;

    function automatic logic [REG_W-1:0] ver_word(input logic [3:0] v);
        return {v, {(REG_W-4){1'b0}}};
    endfunction

    function automatic logic [REG_W-1:0] ctrl_merge(
        input logic [REG_W-1:0] old_w,
        input logic [REG_W-1:0] new_w,
        input logic [REG_W-1:0] ver
    );
        logic [REG_W-1:0] wr_part;
        wr_part = (new_w == '0) ? DRAIN_M : (new_w & ~PROT_MASK);
        return (old_w & PROT_MASK) | wr_part | ver;
    endfunction

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
    import dma_csr_pkg::*;
(
    input  logic                     wr_en,
    input  logic [OFS_W-1:0]         wr_addr,
    input  logic [REG_W-1:0]         wr_data,
    output wr_req_t                  req
);
    always_comb begin
        req.en   = wr_en;
        req.sel  = reg_sel_e'(wr_addr);
        req.data = wr_data;
    end
endmodule

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
    import dma_csr_pkg::*;
#(
    parameter logic [3:0] VERSION = 4'hA
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    input  logic             xfer_done,
    output logic [REG_W-1:0] ctrl_q
);
    localparam logic [REG_W-1:0] VER_W = ver_word(VERSION);

    logic [REG_W-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        // pending soft reset: drop writable bits and loaded flag
        if (ctrl_q[B_SRST]) begin
            ctrl_d = ctrl_q & PROT_MASK & ~LOADED_M;
        end
        if (req.en && req.sel == SEL_CTRL) begin
            ctrl_d = ctrl_merge(ctrl_d, req.data, VER_W);
        end
        if (req.en && req.sel == SEL_ADDR) begin
            ctrl_d = ctrl_d | LOADED_M;
        end
        if (xfer_done) begin
            ctrl_d = ctrl_d | PEND_M;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= VER_W;
        else     ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/dma_csr_data.sv
module dma_csr_data
    import dma_csr_pkg::*;
#(
    parameter int NREG = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  wr_req_t                     req,
    output logic [NREG-1:0][REG_W-1:0]  regs_q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [OFS_W-1:0] MY_OFS = OFS_W'(int'(SEL_ADDR) + i);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (req.en && req.sel == reg_sel_e'(MY_OFS)) begin
                regs_q[i] <= req.data;
            end
        end
    end
endmodule

// File: rtl/dma_csr_regfile.sv
module dma_csr_regfile
    import dma_csr_pkg::*;
#(
    parameter logic [3:0] VERSION = 4'hA
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [OFS_W-1:0] rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             xfer_done,
    output logic             irq
);
    localparam int NDATA = 2;

    wr_req_t                        req;
    logic [REG_W-1:0]               ctrl_q;
    logic [NDATA-1:0][REG_W-1:0]    data_q;

    dma_csr_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req     (req)
    );

    dma_csr_ctrl #(.VERSION(VERSION)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .xfer_done (xfer_done),
        .ctrl_q    (ctrl_q)
    );

    dma_csr_data #(.NREG(NDATA)) u_data (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .regs_q (data_q)
    );

    always_comb begin
        case (reg_sel_e'(rd_addr))
            SEL_CTRL: rd_data = ctrl_q;
            SEL_ADDR: rd_data = data_q[0];
            SEL_CNT:  rd_data = data_q[1];
            default:  rd_data = '0;
        endcase
    end

    assign irq = ctrl_q[B_PEND] & ctrl_q[B_IEN];
endmodule

// File: rtl/dma_csr_checker.sv
module dma_csr_checker
    import dma_csr_pkg::*;
#(
    parameter logic [3:0] VERSION = 4'hA
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [OFS_W-1:0] wr_addr,
    input logic [REG_W-1:0] wr_data,
    input logic             xfer_done,
    input logic             irq,
    input logic [REG_W-1:0] ctrl_q
);
    logic wr_ctrl, wr_adr;
    assign wr_ctrl = wr_en && wr_addr == 2'd0;
    assign wr_adr  = wr_en && wr_addr == 2'd1;

    a_r2_prot_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !xfer_done && !ctrl_q[B_SRST])
        |=> ((ctrl_q & PROT_MASK) == ($past(ctrl_q) & PROT_MASK)));

    a_r3_version: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_q[31:28] == VERSION));

    a_r4_drain: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wr_data == '0) |=> ctrl_q[B_DRAIN]);

    a_r5_done_sets: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> ctrl_q[B_PEND]);

    a_r5_enable_raises: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wr_data[B_IEN] && !wr_data[B_SRST] && ctrl_q[B_PEND]) |=> irq);

    a_r9_disable_lowers: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wr_data[B_IEN]) |=> !irq);

    a_r6_loaded: assert property (@(posedge clk) disable iff (rst)
        wr_adr |=> ctrl_q[B_LOADED]);

    a_r7_self_clear: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[B_SRST] && !(wr_ctrl && wr_data[B_SRST])) |=> !ctrl_q[B_SRST]);
endmodule

bind dma_csr_regfile dma_csr_checker #(.VERSION(VERSION)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .xfer_done (xfer_done),
    .irq       (irq),
    .ctrl_q    (ctrl_q)
);

// File: tb/tb_dma_csr_regfile.sv
module tb_dma_csr_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        xfer_done = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] val;
        logic        irqv;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    dma_csr_regfile dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .xfer_done(xfer_done), .irq(irq)
    );

    // monitor: pops each expected item and compares the ports
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            #1;
            begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (rd_data !== e.val || irq !== e.irqv) begin
                    bad++;
                    $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                             e.tag, rd_data, irq, e.val, e.irqv);
                end
            end
        end
    end

    task automatic chk(input logic [1:0] a, input logic [31:0] v,
                       input logic iv, input string tag);
        rd_addr = a;
        exp_q.push_back('{val: v, irqv: iv, tag: tag});
        #2;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        chk(2'd0, 32'hA000_0000, 1'b0, "R1 ctrl reset");
        chk(2'd1, 32'h0, 1'b0, "R1 addr reset");
        chk(2'd2, 32'h0, 1'b0, "R1 count reset");

        // R2/R3: protected bits kept, version forced
        wr(2'd0, 32'h1234_5678);
        chk(2'd0, 32'hA034_5678, 1'b0, "R2 R3 ctrl merge");

        // R7: soft reset visible one cycle, then clears writable bits
        wr(2'd0, 32'hFFFF_FFFF);
        chk(2'd0, 32'hA1FF_FFF8, 1'b0, "R7 srst visible");
        chk(2'd0, 32'hA000_0000, 1'b0, "R7 srst cleared");

        // R4: zero write sets drain
        wr(2'd0, 32'h0);
        chk(2'd0, 32'hA000_0040, 1'b0, "R4 drain on zero");

        // R6: address write sets loaded
        wr(2'd1, 32'hDEAD_BEEF);
        chk(2'd1, 32'hDEAD_BEEF, 1'b0, "R6 addr stored");
        chk(2'd0, 32'hA400_0040, 1'b0, "R6 loaded set");

        // R8: count stored, offset 3 ignored
        wr(2'd2, 32'h0000_0123);
        chk(2'd2, 32'h0000_0123, 1'b0, "R8 count stored");
        wr(2'd3, 32'h5555_AAAA);
        chk(2'd3, 32'h0, 1'b0, "R8 offset3 reads zero");
        chk(2'd0, 32'hA400_0040, 1'b0, "R8 ctrl untouched by offset3");
        chk(2'd1, 32'hDEAD_BEEF, 1'b0, "R8 addr untouched by offset3");
        chk(2'd2, 32'h0000_0123, 1'b0, "R8 count untouched by offset3");

        // R5: done with enable off
        pulse_done();
        chk(2'd0, 32'hA400_0041, 1'b0, "R5 pending set irq gated");

        // R5: enable with pending set raises irq
        wr(2'd0, 32'h0000_0010);
        chk(2'd0, 32'hA400_0011, 1'b1, "R5 enable raises irq");

        // R9: clear enable lowers irq
        wr(2'd0, 32'h0000_0040);
        chk(2'd0, 32'hA400_0041, 1'b0, "R9 disable lowers irq");

        // R7: soft reset keeps pending, clears loaded, data regs untouched
        wr(2'd0, 32'h0000_0080);
        chk(2'd0, 32'hA400_0081, 1'b0, "R7 srst visible 2");
        chk(2'd0, 32'hA000_0001, 1'b0, "R7 keeps pending drops loaded");
        chk(2'd1, 32'hDEAD_BEEF, 1'b0, "R7 addr kept");

        // R2: writing only protected bits changes nothing but is not zero
        wr(2'd0, 32'hFE00_0007);
        chk(2'd0, 32'hA000_0001, 1'b0, "R2 protected write ignored");

        // R3: version forced even when written zeros there
        wr(2'd0, 32'h0000_0018);
        chk(2'd0, 32'hA000_0019, 1'b1, "R3 R5 version kept irq up");

        // R1: hard reset again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(2'd0, 32'hA000_0000, 1'b0, "R1 ctrl after reset");
        chk(2'd1, 32'h0, 1'b0, "R1 addr after reset");

        // R5: done while enabled raises irq one cycle later
        wr(2'd0, 32'h0000_0010);
        chk(2'd0, 32'hA000_0010, 1'b0, "R5 enabled no pending");
        pulse_done();
        chk(2'd0, 32'hA000_0011, 1'b1, "R5 done raises irq");

        wait (exp_q.size() == 0);
        #3;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule